// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt delivery request into a stream of per-processor injections. A request carries an 8-bit destination, a bit choosing physical or logical addressing, a delivery mode, a vector and a trigger-mode bit. The block compares the destination against each processor slot's present flag, physical ID and logical ID. From this it builds a target bitmask.

For fixed delivery, the mask is walked from slot 0 upward, one injection pulse per selected slot per cycle. For lowest-priority delivery, the one selected slot with the smallest priority input receives the interrupt. An empty mask, or any other delivery mode, drops the request. While the block is busy walking a mask, `req_ready` is low and new requests are not taken.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (`req_logical`=0), destination 0xFF selects every slot whose `slot_present` bit is 1.
- R2: In physical mode with any other destination, only the lowest-indexed present slot whose physical ID equals the destination is selected. Higher-indexed matching slots and absent matching slots are not selected.
- R3: In logical mode (`req_logical`=1), destination 0x00 selects no slot.
- R4: In logical mode with a nonzero destination, every present slot is selected when the bitwise AND of its 8-bit logical ID and the destination is nonzero.
- R5: When the resulting mask is empty, no injection pulse is produced.
- R6: Fixed mode (`req_mode`=3'b000) produces one `inj_valid` pulse per selected slot, one per cycle, in ascending slot order. Each pulse carries the request's vector and trigger bit.
- R7: Lowest-priority mode (`req_mode`=3'b001) produces exactly one pulse. It goes to the selected slot with the smallest `slot_prio` value, and ties go to the lower index.
- R8: A request with any `req_mode` value other than 3'b000 or 3'b001 produces no pulse.
- R9: After reset, `inj_valid` is 0 and `req_ready` is 1.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its first pulse is visible after the next edge. While `req_ready` is 0, `req_valid` and the request fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dest | input | 8 | Destination ID or logical mask |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_mode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority |
| req_vector | input | 8 | Interrupt vector |
| req_trig | input | 1 | Trigger mode carried to the injection |
| slot_present | input | NSLOT | Per-slot present flag |
| slot_phys_id | input | NSLOT*8 | Per-slot physical ID, slot i in bits [8i+7:8i] |
| slot_logic_id | input | NSLOT*8 | Per-slot logical ID, slot i in bits [8i+7:8i] |
| slot_prio | input | NSLOT*PRIO_W | Per-slot priority value, lower wins |
| inj_valid | output | 1 | One-cycle injection pulse |
| inj_slot | output | log2(NSLOT) | Target slot index |
| inj_vector | output | 8 | Vector injected |
| inj_trig | output | 1 | Trigger mode injected |

## Verification
Call the accepting edge edge 0. No pulse can be visible at the falling edge right after it. Pulse k of the request, counting from 0, is due at the falling edge after edge k+1. The bench samples every falling edge in a window of NSLOT+2 cycles and compares `inj_valid`, slot, vector and trigger against the position in its own expected list. So a pulse that is early, late, extra or missing fails on the exact cycle. Requests are sent only once `req_ready` reads 1. One sequence holds `req_valid` high with a different vector during a fan-out, and the bench checks that the pulses already in flight are unchanged.

// File: rtl/irq_dest_pkg.sv
// Shared constants for the interrupt destination resolver.
// Assumes mode codes are 3 bits wide; only two codes are delivered.
package irq_dest_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_FIXED  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_LOWEST = 3'b001;
endpackage

// File: rtl/irq_dest_match.sv
// Builds the target-slot bitmask from a destination and per-slot IDs.
// Assumes: ID fields of ID_W bits; the all-ones physical ID means broadcast.
module irq_dest_match #(
    parameter int NSLOT = 8,
    parameter int ID_W  = 8
) (
    input  logic [ID_W-1:0]       dest,
    input  logic                  logical,
    input  logic [NSLOT-1:0]      present,
    input  logic [NSLOT*ID_W-1:0] phys_id,
    input  logic [NSLOT*ID_W-1:0] logic_id,
    output logic [NSLOT-1:0]      mask
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic [NSLOT-1:0] phys_hit;
    logic [NSLOT-1:0] log_hit;
    logic [NSLOT-1:0] phys_first;

    // Per-slot comparisons for both addressing modes.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign phys_hit[g] = present[g] && (phys_id[g*ID_W +: ID_W] == dest);
        assign log_hit[g]  = present[g] && |(logic_id[g*ID_W +: ID_W] & dest);
    end

    // Keep only the lowest-indexed physical hit.
    always_comb begin
        phys_first = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (phys_hit[i]) phys_first = NSLOT'(1) << i;
        end
    end

    // Select the mask for the addressing mode in use.
    always_comb begin
        if (logical)            mask = (dest == '0) ? '0 : log_hit;
        else if (dest == BCAST) mask = present;
        else                    mask = phys_first;
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Picks the selected slot with the smallest priority value as a one-hot.
// Assumes: ties go to the lower index; an empty mask yields zero.
module irq_lowest_pick #(
    parameter int NSLOT  = 8,
    parameter int PRIO_W = 4
) (
    input  logic [NSLOT-1:0]        mask,
    input  logic [NSLOT*PRIO_W-1:0] prio,
    output logic [NSLOT-1:0]        winner
);
    logic [PRIO_W-1:0] best_p;
    logic              found;

    // Linear scan; strict less-than keeps the earlier slot on a tie.
    always_comb begin
        winner = '0;
        best_p = '0;
        found  = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (mask[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
                winner = NSLOT'(1) << i;
                best_p = prio[i*PRIO_W +: PRIO_W];
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_fanout_seq.sv
// Walks a pending slot mask lowest bit first, one registered pulse per cycle.
// Assumes: load is only raised while busy is low.
module irq_fanout_seq #(
    parameter int NSLOT = 8,
    parameter int VEC_W = 8,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NSLOT-1:0]  load_mask,
    input  logic [VEC_W-1:0]  load_vec,
    input  logic              load_trig,
    output logic              busy,
    output logic              inj_valid,
    output logic [SLOT_W-1:0] inj_slot,
    output logic [VEC_W-1:0]  inj_vector,
    output logic              inj_trig
);
    logic [NSLOT-1:0]  pending;
    logic [NSLOT-1:0]  low_oh;
    logic [SLOT_W-1:0] low_idx;
    logic [VEC_W-1:0]  vec_q;
    logic              trig_q;

    assign busy   = |pending;
    assign low_oh = pending & (~pending + NSLOT'(1));

    // Encode the isolated lowest pending bit as an index.
    always_comb begin
        low_idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (low_oh[i]) low_idx = SLOT_W'(i);
        end
    end

    // Hold the request payload and retire one pending slot per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= '0;
            vec_q      <= '0;
            trig_q     <= 1'b0;
            inj_valid  <= 1'b0;
            inj_slot   <= '0;
            inj_vector <= '0;
            inj_trig   <= 1'b0;
        end else begin
            inj_valid <= busy;
            if (busy) begin
                inj_slot   <= low_idx;
                inj_vector <= vec_q;
                inj_trig   <= trig_q;
                pending    <= pending & ~low_oh;
            end
            if (load) begin
                pending <= load_mask;
                vec_q   <= load_vec;
                trig_q  <= load_trig;
            end
        end
    end
endmodule

// File: rtl/irq_dest_resolver.sv
// Top level: resolves a delivery request to slots and emits injections.
// Assumes NSLOT >= 2; requests are taken only when req_ready is high.
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int ID_W   = 8,
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ID_W-1:0]         req_dest,
    input  logic                    req_logical,
    input  logic [MODE_W-1:0]       req_mode,
    input  logic [VEC_W-1:0]        req_vector,
    input  logic                    req_trig,
    input  logic [NSLOT-1:0]        slot_present,
    input  logic [NSLOT*ID_W-1:0]   slot_phys_id,
    input  logic [NSLOT*ID_W-1:0]   slot_logic_id,
    input  logic [NSLOT*PRIO_W-1:0] slot_prio,
    output logic                    inj_valid,
    output logic [SLOT_W-1:0]       inj_slot,
    output logic [VEC_W-1:0]        inj_vector,
    output logic                    inj_trig
);
    logic [NSLOT-1:0] dest_mask;
    logic [NSLOT-1:0] lp_winner;
    logic [NSLOT-1:0] work_mask;
    logic             busy;
    logic             accept;

    irq_dest_match #(.NSLOT(NSLOT), .ID_W(ID_W)) u_match (
        .dest(req_dest), .logical(req_logical), .present(slot_present),
        .phys_id(slot_phys_id), .logic_id(slot_logic_id), .mask(dest_mask)
    );

    irq_lowest_pick #(.NSLOT(NSLOT), .PRIO_W(PRIO_W)) u_pick (
        .mask(dest_mask), .prio(slot_prio), .winner(lp_winner)
    );

    // Choose the slot set to walk for the requested delivery mode.
    always_comb begin
        case (req_mode)
            MODE_FIXED:  work_mask = dest_mask;
            MODE_LOWEST: work_mask = lp_winner;
            default:     work_mask = '0;
        endcase
    end

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;

    irq_fanout_seq #(.NSLOT(NSLOT), .VEC_W(VEC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_mask(work_mask),
        .load_vec(req_vector), .load_trig(req_trig), .busy(busy),
        .inj_valid(inj_valid), .inj_slot(inj_slot),
        .inj_vector(inj_vector), .inj_trig(inj_trig)
    );
endmodule

// File: rtl/irq_dest_resolver_chk.sv
// Temporal checks on the resolver's ports, bound into every instance.
module irq_dest_resolver_chk #(
    parameter int NSLOT  = 8,
    parameter int ID_W   = 8,
    parameter int VEC_W  = 8,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ID_W-1:0]   req_dest,
    input logic              req_logical,
    input logic [2:0]        req_mode,
    input logic              inj_valid,
    input logic [SLOT_W-1:0] inj_slot,
    input logic [VEC_W-1:0]  inj_vector,
    input logic              inj_trig
);
    logic acc;
    assign acc = req_valid && req_ready;

    // Back-to-back pulses belong to one request and climb in slot order (R6).
    p_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid && $past(inj_valid) |-> inj_slot > $past(inj_slot));

    // One request keeps its vector and trigger across its pulses (R6).
    p_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid && $past(inj_valid) |-> $stable(inj_vector) && $stable(inj_trig));

    // A busy block always emits on the next cycle (R10).
    p_progress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> inj_valid);

    // Lowest-priority delivers no second pulse (R7).
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode == 3'b001 |=> ##2 !inj_valid);

    // Unsupported modes give no pulse (R8).
    p_drop_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_mode > 3'b001 |=> ##1 !inj_valid);

    // Logical destination zero gives no pulse (R3).
    p_log_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_logical && req_dest == '0 |=> ##1 !inj_valid);
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
    .NSLOT(NSLOT), .ID_W(ID_W), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
    .inj_valid(inj_valid), .inj_slot(inj_slot), .inj_vector(inj_vector),
    .inj_trig(inj_trig)
);

// File: tb/irq_dest_resolver_bench.sv
`timescale 1ns/1ps
module irq_dest_resolver_bench;
    localparam int NSLOT = 8;
    localparam int PW    = 4;
    localparam int WIN   = NSLOT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_dest = '0;
    logic req_logical = 1'b0;
    logic [2:0] req_mode = '0;
    logic [7:0] req_vector = '0;
    logic req_trig = 1'b0;
    logic [NSLOT-1:0] slot_present;
    logic [NSLOT*8-1:0] slot_phys_id;
    logic [NSLOT*8-1:0] slot_logic_id;
    logic [NSLOT*PW-1:0] slot_prio;
    logic inj_valid;
    logic [2:0] inj_slot;
    logic [7:0] inj_vector;
    logic inj_trig;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    irq_dest_resolver #(.NSLOT(NSLOT), .PRIO_W(PW)) u_irq_dest_resolver (.*);

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [NSLOT-1:0] exp_mask(logic [7:0] d, logic lg);
        logic [NSLOT-1:0] m = '0;
        if (lg) begin
            if (d != 0)
                for (int i = 0; i < NSLOT; i++)
                    if (slot_present[i] && (slot_logic_id[i*8 +: 8] & d) != 0) m[i] = 1'b1;
        end else if (d == 8'hFF) begin
            m = slot_present;
        end else begin
            for (int i = 0; i < NSLOT; i++)
                if (m == 0 && slot_present[i] && slot_phys_id[i*8 +: 8] == d) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Sends one request and checks every cycle of the result window.
    task automatic run_req(input logic [7:0] d, input logic lg, input logic [2:0] md,
                           input logic [7:0] vec, input logic tg, input int hold,
                           input string tag);
        logic [NSLOT-1:0] m;
        int exp_list[NSLOT];
        int nexp = 0;
        int best;
        m = exp_mask(d, lg);
        if (md == 3'b000) begin
            for (int i = 0; i < NSLOT; i++) if (m[i]) begin exp_list[nexp] = i; nexp++; end
        end else if (md == 3'b001 && m != 0) begin
            best = -1;
            for (int i = 0; i < NSLOT; i++)
                if (m[i] && (best < 0 || slot_prio[i*PW +: PW] < slot_prio[best*PW +: PW])) best = i;
            exp_list[0] = best; nexp = 1;
        end
        check(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
        req_dest = d; req_logical = lg; req_mode = md; req_vector = vec; req_trig = tg;
        req_valid = 1'b1;
        @(posedge clk);
        for (int j = 0; j < WIN; j++) begin
            @(negedge clk);
            if (j < hold) begin
                req_valid = 1'b1; req_vector = ~vec; req_trig = ~tg;
            end else begin
                req_valid = 1'b0;
            end
            if (j >= 1 && j - 1 < nexp) begin
                check(inj_valid == 1'b1, tag, "pulse due", int'(inj_valid), 1);
                check(inj_slot == exp_list[j-1][2:0], tag, "slot", int'(inj_slot), exp_list[j-1]);
                check(inj_vector == vec && inj_trig == tg, tag, "vector/trig",
                      int'({inj_trig, inj_vector}), int'({tg, vec}));
            end else begin
                check(inj_valid == 1'b0, tag, "no pulse", int'(inj_valid), 0);
            end
        end
    endtask

    function automatic string tag_of(logic [7:0] d, logic lg, logic [2:0] md);
        string a, b;
        if (lg) a = (d == 0) ? "R3" : "R4";
        else    a = (d == 8'hFF) ? "R1" : "R2";
        if (exp_mask(d, lg) == 0) a = {a, "/R5"};
        b = (md == 3'b000) ? "R6" : (md == 3'b001) ? "R7" : "R8";
        return {a, "/", b};
    endfunction

    initial begin
        // Slots 1 and 5 absent; slots 1,2,5,6 share physical ID 0x07.
        slot_present = 8'b1101_1101;
        for (int i = 0; i < NSLOT; i++) begin
            slot_phys_id[i*8 +: 8]  = (i == 1 || i == 2 || i == 5 || i == 6) ? 8'h07 : 8'(8'h10 + i);
            slot_logic_id[i*8 +: 8] = (i == 3) ? 8'h0C : (i == 7) ? 8'h81 : 8'(1 << i);
            slot_prio[i*PW +: PW]   = 4'((i * 3) % 4);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(inj_valid == 1'b0, "R9", "inj_valid after reset", int'(inj_valid), 0);
        check(req_ready == 1'b1, "R9", "req_ready after reset", int'(req_ready), 1);

        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < NSLOT; i++) slot_prio[i*PW +: PW] = 4'((i * 3 + r) % 4);
            for (int d = 0; d < 256; d++)
                for (int lg = 0; lg < 2; lg++)
                    for (int md = 0; md < 2; md++)
                        run_req(8'(d), 1'(lg), 3'(md), 8'(d + 3 * r), 1'(d + md), 0,
                                tag_of(8'(d), 1'(lg), 3'(md)));
        end
        // R8: every unsupported mode code, broadcast destination
        for (int md = 2; md < 8; md++)
            run_req(8'hFF, 1'b0, 3'(md), 8'h42, 1'b1, 0, "R8");
        // R10: request held during a fixed fan-out is ignored
        run_req(8'hFF, 1'b0, 3'b000, 8'hAA, 1'b0, 3, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule